// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron Updater

This block is a time-multiplexed neuron engine. One state memory holds the synaptic current, membrane voltage, refractory counter, activity trace and threshold offset of every neuron. A single update datapath is shared by all of them. A strobe on `step_i` starts one algorithmic time step. The engine then services neurons `0` to the configured last index, one per clock, in ascending order. For each neuron it presents the index on `in_idx_o` and reads that neuron's accumulated input for the step on `in_data_i` in the same cycle.

Each service decays the current, adds the input and integrates the new current into a leaky voltage. The voltage is compared with the neuron's adaptive threshold. When the neuron fires, the engine emits its index on the spike stream, clears the voltage and starts a refractory hold. A 16-bit LFSR gives a repeatable pseudo-random value. That value can perturb the current or the voltage, or it can lengthen the refractory hold. Each neuron keeps a trace of its own firing, and the trace pushes its threshold up or down against two watermarks.

Software sets the parameters through a write-only configuration port. `step_done_o` marks the end of each walk.

Top module: `lif_engine`

## Requirements
- R1: After reset: `spike_valid_o` and `step_done_o` are low and `in_idx_o` is 0. All neuron state is zero, the LFSR holds `LFSR_SEED`, and the configuration holds its defaults.
- R2: A step walks indices 0..last, one per cycle, and `in_idx_o` shows the neuron being serviced. If neuron k fires, `spike_valid_o` is high with `spike_idx_o`=k in the cycle after its service.
- R3: `step_done_o` is a one-cycle pulse. It is visible in the same cycle as the spike of the last neuron. A `step_i` raised during a walk is ignored.
- R4: Current update: `cur' = sat16(cur - (cur >>> cur_shift) + in + current_noise)`. The input and noise terms are added only when the neuron is not refractory.
- R5: Voltage update: `v' = sat24(v - (v >>> volt_shift) + cur' + voltage_noise)`. A neuron that is not refractory fires when `v' >= threshold`, and its voltage is then stored as 0.
- R6: On firing, the refractory count loads `refr_len` (plus jitter), saturating at 255. While the count is nonzero, input is dropped, no spike occurs, the voltage stays 0, and the count drops by one per step.
- R7: Noise mode (config address 8, bits [1:0]) has four settings. 0 means no noise. 1 adds `signed(lfsr) >>> noise_shift` to the voltage. 2 adds the same value to the current. 3 adds `lfsr[2:0]` to the refractory load.
- R8: The LFSR shifts right with feedback mask 0xB400 once per serviced neuron. The noise for a neuron uses the value before that shift. Writing address 9 loads bits [15:0], and a zero seed loads 1.
- R9: Trace update: `trace' = sat_u16(trace - (trace >> trace_shift) + (fired ? trace_inc : 0))`.
- R10: After the trace update, the threshold offset changes. It drops by `adapt_step` if `trace' < wm_lo` and rises by `adapt_step` if `trace' > wm_hi`, saturating at signed 16 bits. The threshold is `base_thr + offset`, clamped to at least 1.
- R11: Config map, with reset values in parentheses. Address 0 is the last index (NUM_NEURONS-1); larger writes clamp to NUM_NEURONS-1. Address 1 holds the shifts: cur [3:0] (2), volt [7:4] (3), trace [11:8] (3), noise [15:12] (8). Address 2 is `base_thr` [23:0] (1000). Address 3 is `refr_len` [7:0] (2). Address 4 is `trace_inc` [7:0] (64). Address 5 is `wm_lo` [15:0] (0). Address 6 is `wm_hi` [15:0] (0xFFFF). Address 7 is `adapt_step` [7:0] (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Time-step start strobe |
| in_idx_o | output | $clog2(NUM_NEURONS) | Index of the neuron being serviced |
| in_data_i | input | 16 | Signed accumulated input for `in_idx_o`, same cycle |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 4 | Configuration address |
| cfg_wdata_i | input | 24 | Configuration write data |
| spike_valid_o | output | 1 | Spike event valid |
| spike_idx_o | output | $clog2(NUM_NEURONS) | Index of the firing neuron |
| step_done_o | output | 1 | Pulse after the last neuron of a step |

## Verification
The bench drives six neurons with a fixed mix of inputs: zero, small positive, near-threshold, negative, and full-scale positive and negative. The zero and full-scale neurons separate correct saturation and decay from wrap-around. The near-threshold neurons expose off-by-one errors in the comparison. Heavy constant drive under a refractory length tells dropped input apart from integrated input, and shows exactly when firing resumes. Noise runs in each mode, from the reset seed, a loaded seed and a zero seed, pin down the LFSR order and the point at which it advances. Adaptation runs with tight watermarks, and a run with a deeply negative offset exposes a missing threshold clamp through a zero-input neuron that must stay silent.

// File: rtl/lif_pkg.sv
package lif_pkg;

  localparam int CUR_W   = 16;
  localparam int VOLT_W  = 24;
  localparam int REFR_W  = 8;
  localparam int TRACE_W = 16;
  localparam int OFS_W   = 16;
  localparam int LFSR_W  = 16;
  localparam int JIT_W   = 3;
  localparam int CFG_AW  = 4;
  localparam int CFG_DW  = 24;
  localparam logic [LFSR_W-1:0] LFSR_POLY = 16'hB400;

  localparam logic [CFG_AW-1:0] CFG_LAST  = 4'd0;
  localparam logic [CFG_AW-1:0] CFG_SHIFT = 4'd1;
  localparam logic [CFG_AW-1:0] CFG_THR   = 4'd2;
  localparam logic [CFG_AW-1:0] CFG_REFR  = 4'd3;
  localparam logic [CFG_AW-1:0] CFG_TINC  = 4'd4;
  localparam logic [CFG_AW-1:0] CFG_WLO   = 4'd5;
  localparam logic [CFG_AW-1:0] CFG_WHI   = 4'd6;
  localparam logic [CFG_AW-1:0] CFG_ASTEP = 4'd7;
  localparam logic [CFG_AW-1:0] CFG_NOISE = 4'd8;
  localparam logic [CFG_AW-1:0] CFG_SEED  = 4'd9;

  typedef enum logic [1:0] {
    NZ_OFF  = 2'd0,
    NZ_VOLT = 2'd1,
    NZ_CUR  = 2'd2,
    NZ_REFR = 2'd3
  } noise_mode_e;

  typedef struct packed {
    logic signed [CUR_W-1:0]  cur;
    logic signed [VOLT_W-1:0] volt;
    logic [REFR_W-1:0]        refr;
    logic [TRACE_W-1:0]       trace;
    logic signed [OFS_W-1:0]  thr_ofs;
  } nrn_state_t;

  typedef struct packed {
    logic [3:0]         cur_shift;
    logic [3:0]         volt_shift;
    logic [3:0]         trace_shift;
    logic [3:0]         noise_shift;
    logic [VOLT_W-1:0]  base_thr;
    logic [REFR_W-1:0]  refr_len;
    logic [7:0]         trace_inc;
    logic [TRACE_W-1:0] wm_lo;
    logic [TRACE_W-1:0] wm_hi;
    logic [7:0]         adapt_step;
    noise_mode_e        noise_mode;
  } nrn_cfg_t;

  function automatic logic signed [15:0] sat16(input logic signed [17:0] x);
    if (x > 18'sd32767)       return 16'sh7fff;
    else if (x < -18'sd32768) return 16'sh8000;
    else                      return x[15:0];
  endfunction

  function automatic logic signed [VOLT_W-1:0] sat_volt(input logic signed [VOLT_W+1:0] x);
    if (x > 26'sd8388607)       return 24'sh7fffff;
    else if (x < -26'sd8388608) return 24'sh800000;
    else                        return x[VOLT_W-1:0];
  endfunction

  function automatic logic [REFR_W-1:0] sat_refr(input logic [REFR_W:0] x);
    return x[REFR_W] ? '1 : x[REFR_W-1:0];
  endfunction

  function automatic logic [TRACE_W-1:0] sat_trace(input logic [TRACE_W:0] x);
    return x[TRACE_W] ? '1 : x[TRACE_W-1:0];
  endfunction

endpackage

// File: rtl/lif_cfg_regs.sv
module lif_cfg_regs
  import lif_pkg::*;
#(
  parameter int NUM_NEURONS = 1024,
  localparam int IDX_W = $clog2(NUM_NEURONS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output nrn_cfg_t          cfg_o,
  output logic [IDX_W-1:0]  last_idx_o,
  output logic              seed_we_o,
  output logic [LFSR_W-1:0] seed_o
);

  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_NEURONS - 1);

  nrn_cfg_t         cfg_q;
  logic [IDX_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q            <= MAX_IDX;
      cfg_q.cur_shift   <= 4'd2;
      cfg_q.volt_shift  <= 4'd3;
      cfg_q.trace_shift <= 4'd3;
      cfg_q.noise_shift <= 4'd8;
      cfg_q.base_thr    <= VOLT_W'(1000);
      cfg_q.refr_len    <= REFR_W'(2);
      cfg_q.trace_inc   <= 8'd64;
      cfg_q.wm_lo       <= '0;
      cfg_q.wm_hi       <= '1;
      cfg_q.adapt_step  <= 8'd1;
      cfg_q.noise_mode  <= NZ_OFF;
    end else if (we_i) begin
      unique case (addr_i)
        CFG_LAST:  last_q <= (wdata_i[IDX_W-1:0] > MAX_IDX) ? MAX_IDX : wdata_i[IDX_W-1:0];
        CFG_SHIFT: begin
          cfg_q.cur_shift   <= wdata_i[3:0];
          cfg_q.volt_shift  <= wdata_i[7:4];
          cfg_q.trace_shift <= wdata_i[11:8];
          cfg_q.noise_shift <= wdata_i[15:12];
        end
        CFG_THR:   cfg_q.base_thr   <= wdata_i[VOLT_W-1:0];
        CFG_REFR:  cfg_q.refr_len   <= wdata_i[REFR_W-1:0];
        CFG_TINC:  cfg_q.trace_inc  <= wdata_i[7:0];
        CFG_WLO:   cfg_q.wm_lo      <= wdata_i[TRACE_W-1:0];
        CFG_WHI:   cfg_q.wm_hi      <= wdata_i[TRACE_W-1:0];
        CFG_ASTEP: cfg_q.adapt_step <= wdata_i[7:0];
        CFG_NOISE: cfg_q.noise_mode <= noise_mode_e'(wdata_i[1:0]);
        default: ;
      endcase
    end
  end

  assign cfg_o      = cfg_q;
  assign last_idx_o = last_q;
  assign seed_we_o  = we_i && (addr_i == CFG_SEED);
  assign seed_o     = wdata_i[LFSR_W-1:0];

  AST_LAST_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_q <= MAX_IDX); // R11

endmodule

// File: rtl/lif_lfsr.sv
module lif_lfsr
  import lif_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [LFSR_W-1:0] rnd_o
);

  logic [LFSR_W-1:0] q;
  logic [LFSR_W-1:0] q_next;

  assign q_next = (q >> 1) ^ (q[0] ? LFSR_POLY : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= (SEED == '0) ? LFSR_W'(1) : SEED;
    else if (load_i)  q <= (seed_i == '0) ? LFSR_W'(1) : seed_i;
    else if (adv_i)   q <= q_next;
  end

  assign rnd_o = q;

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0); // R8
  AST_LFSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(adv_i) && !$past(load_i) |-> $stable(q)); // R8

endmodule

// File: rtl/lif_neuron_dp.sv
module lif_neuron_dp
  import lif_pkg::*;
(
  input  nrn_state_t              st_i,
  input  logic signed [CUR_W-1:0] in_i,
  input  logic [LFSR_W-1:0]       rnd_i,
  input  nrn_cfg_t                cfg_i,
  output nrn_state_t              st_o,
  output logic                    fire_o
);

  logic signed [CUR_W-1:0]  cur_q, nz_s, nz_cur, cur_n;
  logic signed [VOLT_W-1:0] volt_q, nz_volt, volt_n;
  logic signed [OFS_W-1:0]  ofs_q;
  logic signed [CUR_W+1:0]  cur_sum, ofs_sum;
  logic signed [VOLT_W+1:0] volt_sum, thr_eff;
  logic [REFR_W:0]          refr_sum;
  logic [TRACE_W:0]         tr_sum;
  logic [TRACE_W-1:0]       tr_n;
  logic                     refr_act, fire;

  always_comb begin
    cur_q    = st_i.cur;
    volt_q   = st_i.volt;
    ofs_q    = st_i.thr_ofs;
    refr_act = (st_i.refr != '0);

    nz_s    = $signed(rnd_i) >>> cfg_i.noise_shift;
    nz_cur  = (cfg_i.noise_mode == NZ_CUR)  ? nz_s : '0;
    nz_volt = (cfg_i.noise_mode == NZ_VOLT) ? VOLT_W'(nz_s) : '0;

    // input and current noise are dropped while refractory
    cur_sum = (CUR_W+2)'(cur_q) - (CUR_W+2)'(cur_q >>> cfg_i.cur_shift);
    if (!refr_act) cur_sum = cur_sum + (CUR_W+2)'(in_i) + (CUR_W+2)'(nz_cur);
    cur_n = sat16(cur_sum);

    volt_sum = (VOLT_W+2)'(volt_q) - (VOLT_W+2)'(volt_q >>> cfg_i.volt_shift)
             + (VOLT_W+2)'(cur_n) + (VOLT_W+2)'(nz_volt);
    volt_n = sat_volt(volt_sum);

    thr_eff = $signed({2'b00, cfg_i.base_thr}) + (VOLT_W+2)'(ofs_q);
    if (thr_eff < (VOLT_W+2)'(1)) thr_eff = (VOLT_W+2)'(1);

    fire = !refr_act && ((VOLT_W+2)'(volt_n) >= thr_eff);

    refr_sum = {1'b0, cfg_i.refr_len}
             + ((cfg_i.noise_mode == NZ_REFR) ? (REFR_W+1)'(rnd_i[JIT_W-1:0]) : '0);

    tr_sum = {1'b0, st_i.trace} - {1'b0, st_i.trace >> cfg_i.trace_shift}
           + (fire ? (TRACE_W+1)'(cfg_i.trace_inc) : '0);
    tr_n = sat_trace(tr_sum);

    if (tr_n < cfg_i.wm_lo)
      ofs_sum = (OFS_W+2)'(ofs_q) - $signed({10'b0, cfg_i.adapt_step});
    else if (tr_n > cfg_i.wm_hi)
      ofs_sum = (OFS_W+2)'(ofs_q) + $signed({10'b0, cfg_i.adapt_step});
    else
      ofs_sum = (OFS_W+2)'(ofs_q);

    st_o.cur     = cur_n;
    st_o.volt    = (refr_act || fire) ? '0 : volt_n;
    st_o.refr    = fire ? sat_refr(refr_sum) : (refr_act ? st_i.refr - 1'b1 : '0);
    st_o.trace   = tr_n;
    st_o.thr_ofs = sat16(ofs_sum);
    fire_o       = fire;
  end

endmodule

// File: rtl/lif_engine.sv
module lif_engine
  import lif_pkg::*;
#(
  parameter int                NUM_NEURONS = 1024,
  parameter logic [LFSR_W-1:0] LFSR_SEED   = 16'hACE1,
  localparam int IDX_W = $clog2(NUM_NEURONS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  output logic [IDX_W-1:0]        in_idx_o,
  input  logic signed [CUR_W-1:0] in_data_i,
  input  logic                    cfg_we_i,
  input  logic [CFG_AW-1:0]       cfg_addr_i,
  input  logic [CFG_DW-1:0]       cfg_wdata_i,
  output logic                    spike_valid_o,
  output logic [IDX_W-1:0]        spike_idx_o,
  output logic                    step_done_o
);

  nrn_cfg_t          cfg;
  logic [IDX_W-1:0]  last_idx;
  logic              seed_we;
  logic [LFSR_W-1:0] seed_val;
  logic [LFSR_W-1:0] rnd;

  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  nrn_state_t        mem_q [NUM_NEURONS];
  nrn_state_t        cur_st, nxt_st;
  logic              fire;

  lif_cfg_regs #(.NUM_NEURONS(NUM_NEURONS)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .cfg_o      (cfg),
    .last_idx_o (last_idx),
    .seed_we_o  (seed_we),
    .seed_o     (seed_val)
  );

  lif_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (busy_q),
    .load_i (seed_we),
    .seed_i (seed_val),
    .rnd_o  (rnd)
  );

  assign cur_st = mem_q[idx_q];

  lif_neuron_dp u_dp (
    .st_i   (cur_st),
    .in_i   (in_data_i),
    .rnd_i  (rnd),
    .cfg_i  (cfg),
    .st_o   (nxt_st),
    .fire_o (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q        <= 1'b0;
      idx_q         <= '0;
      spike_valid_o <= 1'b0;
      spike_idx_o   <= '0;
      step_done_o   <= 1'b0;
    end else begin
      spike_valid_o <= 1'b0;
      step_done_o   <= 1'b0;
      if (!busy_q) begin
        if (step_i) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
        end
      end else begin
        spike_valid_o <= fire;
        spike_idx_o   <= idx_q;
        if (idx_q >= last_idx) begin
          busy_q      <= 1'b0;
          idx_q       <= '0;
          step_done_o <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_NEURONS; i++) mem_q[i] <= '0;
    end else if (busy_q) begin
      mem_q[idx_q] <= nxt_st;
    end
  end

  assign in_idx_o = idx_q;

  AST_IDX_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> idx_q == $past(idx_q) + 1'b1); // R2
  AST_SPIKE_FROM_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spike_valid_o |-> $past(busy_q)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |=> !step_done_o); // R3
  AST_DONE_ENDS_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |-> !busy_q && $past(busy_q)); // R3
  AST_REFR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (cur_st.refr != '0) |-> !fire); // R6

endmodule

// File: tb/lif_engine_tb.sv
`timescale 1ns/1ps
module lif_engine_tb;

  localparam int NN = 6;
  localparam int IW = $clog2(NN);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              step = 1'b0;
  logic [IW-1:0]     in_idx;
  logic signed [15:0] in_data;
  logic              cfg_we = 1'b0;
  logic [3:0]        cfg_addr = '0;
  logic [23:0]       cfg_wdata = '0;
  logic              spk_v;
  logic [IW-1:0]     spk_idx;
  logic              done;

  always #2 clk = ~clk;

  lif_engine #(.NUM_NEURONS(NN), .LFSR_SEED(16'hACE1)) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .step_i        (step),
    .in_idx_o      (in_idx),
    .in_data_i     (in_data),
    .cfg_we_i      (cfg_we),
    .cfg_addr_i    (cfg_addr),
    .cfg_wdata_i   (cfg_wdata),
    .spike_valid_o (spk_v),
    .spike_idx_o   (spk_idx),
    .step_done_o   (done)
  );

  int stim [NN];
  always_comb in_data = 16'(stim[in_idx]);

  int n_checks = 0;
  int n_err = 0;

  // reference model state
  int m_cur [NN], m_volt [NN], m_refr [NN], m_tr [NN], m_ofs [NN];
  int c_last = NN - 1, c_cs = 2, c_vs = 3, c_ts = 3, c_ns = 8;
  int c_base = 1000, c_refr = 2, c_inc = 64, c_lo = 0, c_hi = 65535, c_step = 1, c_mode = 0;
  logic [15:0] m_lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampi(input int x, input int lo, input int hi);
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  task automatic model_step(output int mask);
    mask = 0;
    for (int k = 0; k <= c_last; k++) begin
      int nv, cd, cn, vn, thr, rf, tr;
      bit fire, refr;
      nv   = int'($signed(m_lfsr)) >>> c_ns;
      refr = (m_refr[k] != 0);
      cd   = m_cur[k] - (m_cur[k] >>> c_cs);
      if (!refr) cd = cd + stim[k] + ((c_mode == 2) ? nv : 0);
      cn   = clampi(cd, -32768, 32767);
      vn   = m_volt[k] - (m_volt[k] >>> c_vs) + cn + ((c_mode == 1) ? nv : 0);
      vn   = clampi(vn, -8388608, 8388607);
      thr  = c_base + m_ofs[k];
      if (thr < 1) thr = 1;
      fire = !refr && (vn >= thr);
      if (fire) mask |= (1 << k);
      rf   = fire ? clampi(c_refr + ((c_mode == 3) ? int'(m_lfsr[2:0]) : 0), 0, 255)
                  : (refr ? m_refr[k] - 1 : 0);
      tr   = clampi(m_tr[k] - (m_tr[k] >> c_ts) + (fire ? c_inc : 0), 0, 65535);
      if (tr < c_lo)      m_ofs[k] = clampi(m_ofs[k] - c_step, -32768, 32767);
      else if (tr > c_hi) m_ofs[k] = clampi(m_ofs[k] + c_step, -32768, 32767);
      m_cur[k]  = cn;
      m_volt[k] = (refr || fire) ? 0 : vn;
      m_refr[k] = rf;
      m_tr[k]   = tr;
      m_lfsr    = (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
    end
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 24'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    case (addr)
      0: c_last = clampi(data & ((1 << IW) - 1), 0, NN - 1);
      1: begin c_cs = data & 15; c_vs = (data >> 4) & 15; c_ts = (data >> 8) & 15; c_ns = (data >> 12) & 15; end
      2: c_base = data & 24'hFFFFFF;
      3: c_refr = data & 255;
      4: c_inc = data & 255;
      5: c_lo = data & 16'hFFFF;
      6: c_hi = data & 16'hFFFF;
      7: c_step = data & 255;
      8: c_mode = data & 3;
      9: m_lfsr = (data[15:0] == 16'h0) ? 16'h0001 : data[15:0];
      default: ;
    endcase
  endtask

  task automatic set_stim(input int a, input int b, input int c, input int d, input int e, input int f);
    stim[0] = a; stim[1] = b; stim[2] = c; stim[3] = d; stim[4] = e; stim[5] = f;
  endtask

  task automatic run_step(input string req, input bit poke);
    int exp_mask, got_mask;
    bit timing_bad, done_bad, idx_bad;
    model_step(exp_mask);
    got_mask = 0; timing_bad = 0; done_bad = 0; idx_bad = 0;
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
    for (int n = 1; n <= c_last + 4; n++) begin
      @(negedge clk);
      if (poke && n == 2) step = 1'b1;
      if (poke && n == 3) step = 1'b0;
      if (n <= c_last && int'(in_idx) != n) idx_bad = 1;
      if (spk_v) begin
        if (n > c_last + 1 || int'(spk_idx) != n - 1) timing_bad = 1;
        else got_mask |= (1 << (n - 1));
      end
      if (done != (n == c_last + 1)) done_bad = 1;
    end
    check(!timing_bad && got_mask == exp_mask, req, "spike mask", timing_bad ? -1 : got_mask, exp_mask);
    check(!idx_bad, "R2", "service index order", idx_bad, 0);
    check(!done_bad, "R3", "step_done timing", done_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R3 watchdog: actual hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < NN; i++) begin
      stim[i] = 0; m_cur[i] = 0; m_volt[i] = 0; m_refr[i] = 0; m_tr[i] = 0; m_ofs[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset outputs
    check(spk_v == 1'b0, "R1", "spike_valid in reset", spk_v, 0);
    check(done == 1'b0, "R1", "step_done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(spk_v == 1'b0 && done == 1'b0 && in_idx == '0, "R1", "idle outputs", {spk_v, done, in_idx}, 0);

    // R11 defaults, R4/R5 integration and saturation
    set_stim(0, 150, 400, -300, 32767, 700);
    for (int s = 0; s < 8; s++) run_step("R5", 1'b0);
    set_stim(-32768, 900, 260, 32767, -32768, 1);
    for (int s = 0; s < 6; s++) run_step("R4", 1'b0);
    set_stim(32767, 0, 1200, -32768, 32767, 350);
    for (int s = 0; s < 6; s++) run_step("R4", 1'b0);

    // R6 refractory, input dropped
    cfg_write(3, 3);
    set_stim(2000, 2000, 600, 0, -5, 30000);
    for (int s = 0; s < 8; s++) run_step("R6", 1'b0);
    cfg_write(3, 255);
    for (int s = 0; s < 4; s++) run_step("R6", 1'b0);
    cfg_write(3, 0);
    for (int s = 0; s < 4; s++) run_step("R6", 1'b0);

    // R7 noise into voltage from the running reset seed (R8)
    cfg_write(2, 300);
    cfg_write(1, 32'h5332);
    cfg_write(8, 1);
    set_stim(0, 0, 0, 50, 100, 0);
    for (int s = 0; s < 6; s++) run_step("R7", 1'b0);
    cfg_write(9, 16'h1234);
    for (int s = 0; s < 6; s++) run_step("R8", 1'b0);
    cfg_write(9, 0);
    for (int s = 0; s < 4; s++) run_step("R8", 1'b0);
    cfg_write(1, 32'h4332);
    cfg_write(8, 2);
    for (int s = 0; s < 6; s++) run_step("R7", 1'b0);
    cfg_write(8, 3);
    cfg_write(3, 1);
    set_stim(5000, 5000, 5000, 5000, 5000, 5000);
    for (int s = 0; s < 8; s++) run_step("R7", 1'b0);
    cfg_write(8, 0);
    cfg_write(3, 0);

    // R9/R10 trace-driven threshold adaptation
    cfg_write(2, 600);
    cfg_write(4, 200);
    cfg_write(5, 100);
    cfg_write(6, 300);
    cfg_write(7, 50);
    set_stim(0, 300, 900, 150, 2000, -100);
    for (int s = 0; s < 16; s++) run_step("R10", 1'b0);
    cfg_write(4, 255);
    cfg_write(1, 32'h8132);
    for (int s = 0; s < 6; s++) run_step("R9", 1'b0);
    // R10 clamp of threshold at 1: zero-input neurons must stay silent
    cfg_write(2, 10);
    cfg_write(5, 60000);
    cfg_write(6, 65535);
    cfg_write(7, 255);
    set_stim(0, 0, 3, 0, 40, 0);
    for (int s = 0; s < 6; s++) run_step("R10", 1'b0);

    // R3 strobe during a walk is ignored
    for (int s = 0; s < 2; s++) run_step("R3", 1'b1);

    // R11 last index and its clamp
    cfg_write(0, 2);
    set_stim(900, 2000, 50, 0, 0, 0);
    for (int s = 0; s < 3; s++) run_step("R11", 1'b0);
    cfg_write(0, 7);
    for (int s = 0; s < 2; s++) run_step("R11", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule